// File: doc/BRIEF.md
# ADC Group Scan Sequencer

This block times the conversions of one analog-to-digital conversion group. A group is a set of input channels picked by a bit mask. When a scan starts, the block takes the set channels from lowest index to highest. Each channel passes through three timed phases: discharge, then sample, then convert. The length of each phase is programmed in clock cycles. A fixed idle gap separates one channel from the next. No gap follows the last channel.

At the start of the convert phase the block sends a one-cycle start pulse to a converter stub and names the channel. It captures the value that comes back with the stub's done strobe. At the end of the convert phase it emits the value with a one-cycle valid strobe and the channel number.

In single-scan mode a trigger pulse starts one scan. In continuous mode the next scan starts as soon as the previous one finishes, with no new trigger. Dropping the enable input ends the activity cleanly at the next channel boundary.

Top module: `adc_scan_seq`

## Requirements
- R1: The `phase` output shows the current phase with these codes: 0 idle, 1 discharge, 2 sample, 3 convert, 4 inter-channel gap. Each selected channel shows code 1 for `dis_len` cycles, then code 2 for `smp_len` cycles, then code 3 for `cnv_len` cycles. So each channel occupies the sum of the three lengths.
- R2: Between two consecutive channels of a scan the phase is 4 for exactly 5 cycles. No gap follows the last channel. A single scan of N channels lasts N×(channel time) + (N−1)×5 cycles, counted from the cycle after the trigger edge.
- R3: Bit i of `ch_mask` selects channel i. Channels are converted in ascending index order, and cleared bits take no time. A trigger with an all-zero mask starts nothing.
- R4: The mask and the three phase lengths are sampled when a scan starts, and later changes do not affect that scan. A length of 0 acts as 1.
- R5: A trigger starts a scan only when `enable` is high and the block is idle. A trigger while a scan runs, or while `enable` is low, is ignored. `busy` is high from the cycle after the accepted trigger edge through the cycle in which the last result is valid, and low otherwise.
- R6: With `continuous` high, the last convert cycle of a scan is followed at once by the discharge phase of the first selected channel of a new scan. The mask and lengths are sampled again at that point, and no trigger is needed.
- R7: When `enable` is low at the end of a convert phase or at the end of a gap, the block goes idle. The result of the channel in progress is still emitted. `busy` falls in the cycle after the last result, or in the first cycle after the gap.
- R8: `conv_start` is high for exactly one cycle, the first convert cycle of each channel, with `conv_ch` holding that channel. `conv_data` is captured when `conv_done` is high during the convert phase.
- R9: `res_valid` is high for one cycle, the cycle right after a channel's last convert cycle. In that cycle `res_ch` holds the channel and `res_data` holds the captured value.
- R10: During and right after reset, `phase` is 0 and `busy`, `conv_start` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows scans to start and to continue |
| continuous | input | 1 | 1 = restart the scan automatically, 0 = one scan per trigger |
| trigger | input | 1 | Start pulse for a scan |
| ch_mask | input | NUM_CH | Channel selection, bit i = channel i |
| dis_len | input | CNT_W | Discharge length in cycles |
| smp_len | input | CNT_W | Sample length in cycles |
| cnv_len | input | CNT_W | Convert length in cycles |
| busy | output | 1 | A scan is in progress |
| phase | output | 3 | Current phase code |
| conv_start | output | 1 | Start pulse to the converter |
| conv_ch | output | log2(NUM_CH) | Channel being converted |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | RES_W | Converter result |
| res_valid | output | 1 | Result strobe |
| res_ch | output | log2(NUM_CH) | Channel of the result |
| res_data | output | RES_W | Result value |

## Verification
The bench follows the phase code every cycle across many random masks and lengths. It compares each cycle against a model built from the timing formula, so a gap that is off by one, a gap left after the last channel, or a set bit that is skipped shows up as a phase or result-timing mismatch.

A length of zero is a corner case: a design that does not treat it as one cycle would either hang or stall the scan. The bench also changes the mask and lengths mid-scan and retriggers mid-scan. A design that does not hold its settings, or that restarts on a retrigger, produces results at the wrong times.

For continuous mode the bench checks the back-to-back restart with no gap. It also drops `enable` once during a sample phase and once during a gap. A sequencer that stops at once would lose the pending result. One that ignores the drop would keep producing results after `busy` should have fallen.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Phase codes, visible on the phase port
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DIS  = 3'd1,
    PH_SMP  = 3'd2,
    PH_CNV  = 3'd3,
    PH_GAP  = 3'd4
  } phase_e;

endpackage

// File: rtl/adc_phase_timer.sv
// Down-counter shared by all timed phases; done is high on the last cycle.
module adc_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R1: a loaded count is what the next cycle holds
  p_load_taken_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)))
    else $error("timer did not take load value");

endmodule

// File: rtl/adc_ch_pick.sv
// Finds the lowest set mask bit at or above a start index.
module adc_ch_pick #(
  parameter  int NUM_CH = 8,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W:0]     from,
  output logic              found,
  output logic [CH_W-1:0]   idx
);

  logic [NUM_CH-1:0] qual;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_qual
    assign qual[g] = mask[g] && (from <= (CH_W+1)'(g));
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int j = NUM_CH - 1; j >= 0; j--) begin
      if (qual[j]) begin
        found = 1'b1;
        idx   = CH_W'(j);
      end
    end
  end

  // R3: a reported channel is always a selected one at or past the start
  always_comb begin
    if (found) begin
      p_pick_hit_r3: assert (mask[idx] && ((CH_W+1)'(idx) >= from))
        else $error("picked channel not selected");
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter  int NUM_CH  = 8,
  parameter  int CNT_W   = 8,
  parameter  int RES_W   = 12,
  parameter  int GAP_CYC = 5,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              continuous,
  input  logic              trigger,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic [CNT_W-1:0]  dis_len,
  input  logic [CNT_W-1:0]  smp_len,
  input  logic [CNT_W-1:0]  cnv_len,
  output logic              busy,
  output logic [2:0]        phase,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_ch,
  output logic [RES_W-1:0]  res_data
);

  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC - 1);
  localparam int               GRUN_W   = $clog2(GAP_CYC + 2);

  // Length-to-counter-load; zero behaves as a one-cycle phase (R4)
  function automatic logic [CNT_W-1:0] len_load(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  phase_e            st, st_n;
  logic [CH_W-1:0]   cur, ch_n;
  logic [NUM_CH-1:0] mask_q;
  logic [CNT_W-1:0]  smp_q, cnv_q, dis_q;
  logic [RES_W-1:0]  cap_q;
  logic              tmr_ld, tmr_done, latch, start_n, emit;
  logic [CNT_W-1:0]  tmr_val;
  logic              first_found, next_found;
  logic [CH_W-1:0]   first_idx, next_idx;

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  // First channel of a fresh scan, taken from the live mask
  adc_ch_pick #(.NUM_CH(NUM_CH)) u_first (
    .mask  (ch_mask),
    .from  ('0),
    .found (first_found),
    .idx   (first_idx)
  );

  // Following channel of the running scan, from the held mask
  adc_ch_pick #(.NUM_CH(NUM_CH)) u_next (
    .mask  (mask_q),
    .from  ((CH_W+1)'(cur) + (CH_W+1)'(1)),
    .found (next_found),
    .idx   (next_idx)
  );

  always_comb begin
    st_n    = st;
    ch_n    = cur;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    latch   = 1'b0;
    start_n = 1'b0;
    emit    = 1'b0;
    case (st)
      PH_IDLE: begin
        if (enable && trigger && first_found) begin
          st_n    = PH_DIS;
          ch_n    = first_idx;
          latch   = 1'b1;
          tmr_ld  = 1'b1;
          tmr_val = len_load(dis_len);
        end
      end
      PH_DIS: begin
        if (tmr_done) begin
          st_n    = PH_SMP;
          tmr_ld  = 1'b1;
          tmr_val = len_load(smp_q);
        end
      end
      PH_SMP: begin
        if (tmr_done) begin
          st_n    = PH_CNV;
          tmr_ld  = 1'b1;
          tmr_val = len_load(cnv_q);
          start_n = 1'b1;
        end
      end
      PH_CNV: begin
        if (tmr_done) begin
          emit = 1'b1;
          if (next_found) begin
            if (enable) begin
              st_n    = PH_GAP;
              tmr_ld  = 1'b1;
              tmr_val = GAP_LOAD;
            end else begin
              st_n = PH_IDLE;
            end
          end else if (continuous && enable && first_found) begin
            st_n    = PH_DIS;
            ch_n    = first_idx;
            latch   = 1'b1;
            tmr_ld  = 1'b1;
            tmr_val = len_load(dis_len);
          end else begin
            st_n = PH_IDLE;
          end
        end
      end
      PH_GAP: begin
        if (tmr_done) begin
          if (enable) begin
            st_n    = PH_DIS;
            ch_n    = next_idx;
            tmr_ld  = 1'b1;
            tmr_val = len_load(dis_q);
          end else begin
            st_n = PH_IDLE;
          end
        end
      end
      default: st_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      cur        <= '0;
      mask_q     <= '0;
      dis_q      <= '0;
      smp_q      <= '0;
      cnv_q      <= '0;
      cap_q      <= '0;
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      res_ch     <= '0;
      res_data   <= '0;
      busy       <= 1'b0;
    end else begin
      st         <= st_n;
      cur        <= ch_n;
      conv_start <= start_n;
      res_valid  <= emit;
      busy       <= (st_n != PH_IDLE) || emit;
      if (latch) begin
        mask_q <= ch_mask;
        dis_q  <= dis_len;
        smp_q  <= smp_len;
        cnv_q  <= cnv_len;
      end
      if (st == PH_CNV && conv_done) cap_q <= conv_data;
      if (emit) begin
        res_ch   <= cur;
        res_data <= (st == PH_CNV && conv_done) ? conv_data : cap_q;
      end
    end
  end

  assign phase   = st;
  assign conv_ch = cur;

  // Length of each gap, counted for the checks below
  logic [GRUN_W-1:0] gap_run;
  always_ff @(posedge clk) begin
    if (rst)               gap_run <= '0;
    else if (st == PH_GAP) gap_run <= gap_run + 1'b1;
    else                   gap_run <= '0;
  end

  // R2: every gap lasts exactly GAP_CYC cycles
  p_gap_len_r2: assert property (@(posedge clk) disable iff (rst)
    (st != PH_GAP && $past(st) == PH_GAP) |-> (gap_run == GRUN_W'(GAP_CYC)))
    else $error("gap length wrong");

  // R8: converter start only in convert phase, never two cycles running
  p_start_in_cnv_r8: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (st == PH_CNV))
    else $error("start outside convert");

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start)
    else $error("start longer than one cycle");

  // R9: a result only follows a convert cycle
  p_res_after_cnv_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(st) == PH_CNV))
    else $error("result not after convert");

  // R5: when not busy the sequencer is idle and silent
  p_idle_when_free_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (st == PH_IDLE && !res_valid))
    else $error("activity while not busy");

  // R6: a convert followed directly by discharge is a restart and carries a result
  p_restart_res_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == PH_CNV && st == PH_DIS) |-> res_valid)
    else $error("restart without result");

endmodule

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;

  localparam int NCH = 8;

  logic       clk = 1'b0, rst = 1'b1;
  logic       enable = 1'b0, continuous = 1'b0, trigger = 1'b0;
  logic [7:0] ch_mask = '0;
  logic [7:0] dis_len = 8'd1, smp_len = 8'd1, cnv_len = 8'd1;
  logic       busy, conv_start, conv_done, res_valid;
  logic [2:0] phase, conv_ch, res_ch;
  logic [11:0] conv_data, res_data;

  adc_scan_seq #(.NUM_CH(NCH), .CNT_W(8), .RES_W(12), .GAP_CYC(5)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .continuous(continuous),
    .trigger(trigger), .ch_mask(ch_mask), .dis_len(dis_len),
    .smp_len(smp_len), .cnv_len(cnv_len), .busy(busy), .phase(phase),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .res_valid(res_valid), .res_ch(res_ch),
    .res_data(res_data)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Converter stub: answers in the same cycle, value = {0, channel, start count}
  logic [7:0] start_cnt = '0;
  always @(posedge clk) begin
    if (rst) start_cnt <= '0;
    else if (conv_start) start_cnt <= start_cnt + 1'b1;
  end
  assign conv_done = conv_start;
  assign conv_data = {1'b0, conv_ch, start_cnt};

  int n_chk = 0, n_fail = 0, res_total = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic int nth_ch(input logic [7:0] m, input int k);
    int left = k;
    for (int i = 0; i < NCH; i++) begin
      if (m[i]) begin
        if (left == 0) return i;
        left--;
      end
    end
    return -1;
  endfunction

  function automatic int exp_phase(input int q, input int n, input int d,
                                   input int s, input int c);
    int l = d + s + c;
    int idx = q / (l + 5);
    int r = q % (l + 5);
    if (idx >= n) return 0;
    if (r < d) return 1;
    if (r < d + s) return 2;
    if (r < l) return 3;
    if (idx == n - 1) return 0;
    return 4;
  endfunction

  // Walks a scan cycle by cycle from offset 0 (first cycle after the trigger edge)
  task automatic observe(input logic [7:0] m, input int d, input int s, input int c,
                         input int tc, input int busy_end, input int phase_end,
                         input int res_end, input int drop_o, input int retrig_o,
                         input bit scramble, input string ttag, input string btag);
    int n = $countones(m);
    int l = d + s + c;
    int p = n * l + (n - 1) * 5;
    int ph_e = 0, ph_a = 0, ph_x = 0;
    int tm_e = 0, tm_a = 0, tm_x = 0;
    int dt_e = 0, dt_a = 0, dt_x = 0;
    int cs_e = 0, cs_a = 0, cs_x = 0;
    int bz_e = 0, bz_a = 0, bz_x = 0;
    int nres_o = 0, nres_x = 0;
    for (int o = cyc - tc - 1; o <= busy_end + 16; o = cyc - tc - 1) begin
      int ep, u, q, ech;
      bit ev, es;
      ep = (o > phase_end) ? 0 : exp_phase(o % p, n, d, s, c);
      if (int'(phase) != ep) begin
        if (ph_e == 0) begin ph_a = int'(phase); ph_x = ep; end
        ph_e++;
      end
      u = o - l;
      ev = (u >= 0) && (o <= res_end) && (((u % p) % (l + 5)) == 0) &&
           (((u % p) / (l + 5)) < n);
      if (ev) nres_x++;
      if (res_valid) nres_o++;
      if (res_valid != ev) begin
        if (tm_e == 0) begin tm_a = o; tm_x = ev; end
        tm_e++;
      end
      if (res_valid && ev) begin
        logic [11:0] exp_d;
        ech = nth_ch(m, (u % p) / (l + 5));
        exp_d = {1'b0, 3'(ech), 8'(res_total)};
        if (int'(res_ch) != ech || res_data != exp_d) begin
          if (dt_e == 0) begin dt_a = int'(res_data); dt_x = int'(exp_d); end
          dt_e++;
        end
      end
      if (res_valid) res_total++;
      q = o % p;
      es = (o <= phase_end) && ((q % (l + 5)) == d + s) && ((q / (l + 5)) < n);
      if (conv_start != es ||
          (es && int'(conv_ch) != nth_ch(m, q / (l + 5)))) begin
        if (cs_e == 0) begin cs_a = o; cs_x = es; end
        cs_e++;
      end
      if (busy != (o <= busy_end)) begin
        if (bz_e == 0) begin bz_a = busy; bz_x = (o <= busy_end); end
        bz_e++;
      end
      // stimulus during the scan
      if (scramble && o == 0) begin
        ch_mask = 8'($urandom);
        dis_len = 8'($urandom_range(0, 9));
        smp_len = 8'($urandom_range(0, 9));
        cnv_len = 8'($urandom_range(0, 9));
      end
      if (o == retrig_o) trigger = 1'b1;
      if (o == retrig_o + 1) trigger = 1'b0;
      if (o == drop_o) enable = 1'b0;
      @(negedge clk);
    end
    trigger = 1'b0;
    chk(ph_e == 0, "R1", "phase code", ph_a, ph_x);
    chk(tm_e == 0, ttag, "result strobe timing (offset / expected strobe)", tm_a, tm_x);
    chk(nres_o == nres_x, "R3", "result count", nres_o, nres_x);
    chk(dt_e == 0, "R9", "result channel and data", dt_a, dt_x);
    chk(cs_e == 0, "R8", "converter start (offset / expected)", cs_a, cs_x);
    chk(bz_e == 0, btag, "busy flag", bz_a, bz_x);
  endtask

  task automatic run_single(input logic [7:0] m, input int d, input int s,
                            input int c, input bit retrig);
    int de = eff(d), se = eff(s), ce = eff(c);
    int n = $countones(m);
    int p = n * (de + se + ce) + (n - 1) * 5;
    int tc;
    ch_mask = m; dis_len = 8'(d); smp_len = 8'(s); cnv_len = 8'(c);
    continuous = 1'b0; enable = 1'b1; trigger = 1'b1;
    tc = cyc;
    @(negedge clk);
    trigger = 1'b0;
    // R2 timing, R4 latched settings, R5 retrigger ignored
    observe(m, de, se, ce, tc, p, p - 1, p, -1, retrig ? p / 2 : -1, 1'b1, "R2", "R5");
  endtask

  task automatic run_cont(input logic [7:0] m, input int d, input int s,
                          input int c, input bit gap_stop);
    int de = eff(d), se = eff(s), ce = eff(c);
    int l = de + se + ce;
    int n = $countones(m);
    int p = n * l + (n - 1) * 5;
    int tc;
    ch_mask = m; dis_len = 8'(d); smp_len = 8'(s); cnv_len = 8'(c);
    continuous = 1'b1; enable = 1'b1; trigger = 1'b1;
    tc = cyc;
    @(negedge clk);
    trigger = 1'b0;
    if (gap_stop)  // R7: enable drop inside a gap
      observe(m, de, se, ce, tc, l + 4, l + 4, l, l + 1, -1, 1'b0, "R6", "R7");
    else           // R6 restart, then R7 stop at end of the third scan's first channel
      observe(m, de, se, ce, tc, 2 * p + l, 2 * p + l - 1, 2 * p + l,
              2 * p + de, -1, 1'b0, "R6", "R7");
    enable = 1'b1;
    continuous = 1'b0;
  endtask

  task automatic ignored_trigger(input string tag, input logic [7:0] m, input bit en);
    int bad = 0;
    ch_mask = m; enable = en; continuous = 1'b0; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (busy || res_valid || conv_start || phase != 3'd0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, tag, "cycles with activity after ignored trigger", bad, 0);
    enable = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R10: state while reset is held
    chk(phase == 3'd0 && !busy && !res_valid && !conv_start, "R10",
        "outputs during reset", {phase, busy, res_valid, conv_start}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(phase == 3'd0 && !busy && !res_valid && !conv_start, "R10",
        "outputs after reset", {phase, busy, res_valid, conv_start}, 0);

    run_single(8'b1000_0001, 2, 3, 4, 1'b0);  // R3 skipped middle bits
    run_single(8'b0000_0001, 1, 1, 1, 1'b0);  // one channel, shortest
    run_single(8'b1111_1111, 0, 0, 0, 1'b1);  // R4 zero lengths, R5 retrigger
    run_single(8'b1000_0000, 5, 1, 2, 1'b0);  // highest channel only
    ignored_trigger("R3", 8'h00, 1'b1);       // empty mask
    ignored_trigger("R5", 8'hFF, 1'b0);       // enable low
    run_cont(8'b0010_0110, 1, 2, 3, 1'b0);
    run_cont(8'b0100_0000, 2, 1, 1, 1'b0);    // one channel back to back
    run_cont(8'b0000_0011, 1, 1, 2, 1'b1);

    for (int k = 0; k < 12; k++) begin
      run_single(8'($urandom_range(1, 255)), $urandom_range(0, 4),
                 $urandom_range(0, 4), $urandom_range(0, 4), 1'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule